// File: doc/BRIEF.md
# Multiplierless FIR Filter Using Distributed Arithmetic

This block is a finite impulse response filter that has no multipliers. Each accepted input sample goes into a tap delay line. The delay line is then read one bit-slice at a time, from the most significant slice down to the least. The taps are split into equal groups. Each group owns a small lookup table. One bit from every tap in the group forms the table address, and the table returns the sum of the coefficients whose bits are set. The group outputs are added together. A shift-and-add accumulator then weights each slice by its bit position, and the product is never formed.

The `RADIX_BITS` parameter sets how many input bits are consumed per clock. Each extra bit adds a parallel copy of the table set. A sample therefore takes `DATA_W/RADIX_BITS` processing cycles plus one emit cycle. The control is a three-state machine:
- `ST_IDLE` waits for a sample.
- `ST_SLICE` runs the bit-slices.
- `ST_EMIT` registers the result and raises the valid strobe.

The transitions are:
- IDLE→SLICE on an accepted sample.
- SLICE→SLICE while slices remain.
- SLICE→EMIT on the last slice.
- EMIT→SLICE when a new sample arrives in that same cycle.
- EMIT→IDLE otherwise.

The coefficients are a parameter, and the table contents are computed from them when the design is elaborated.

Top module: `dafir_fir`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `out_data` is 0. Every tap of the delay line starts at zero, so the first outputs see only the samples accepted since reset.
- R2: For each accepted sample x[n], the next result equals Σ c[i]·x[n−i] for i = 0..NTAPS−1, exact, as a signed OUT_W-bit two's-complement value. Tap 0 is the newest sample. Coefficient c[i] sits in bits [i*CW +: CW] of `COEFS`.
- R3: The input is signed two's complement, and the slice holding the sign bit carries negative weight. The most negative input, −2^(DATA_W−1), gives the exact product.
- R4: A sample accepted at clock edge E produces `out_valid` high in the cycle that follows edge E+NSLICE+1, where NSLICE = DATA_W/RADIX_BITS.
- R5: `out_valid` is high for exactly one cycle per accepted sample.
- R6: An `in_en` that arrives while the state is `ST_SLICE` is ignored. It neither enters the delay line nor produces a result.
- R7: A sample offered in the `ST_EMIT` cycle is accepted. Samples can therefore arrive every NSLICE+1 cycles with no gap.
- R8: `out_data` changes only in the cycle in which `out_valid` is high, and holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_en | input | 1 | Sample strobe; accepted in `ST_IDLE` or `ST_EMIT` |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | OUT_W | Signed filter result, OUT_W = CW+DATA_W+clog2(NTAPS) |

## Verification
The assertions assume that reset is held for at least one clock edge. They place no limit on how often `in_en` is raised or on which values `in_data` carries: any code is legal, and a strobe that arrives while the filter is busy is part of the defined behaviour. The stimulus relies on that freedom:
- It mixes back-to-back samples at the fastest legal spacing with random longer gaps.
- It adds deliberate strobes in the middle of a computation, carrying values that would corrupt the result if they were taken in.
- It adds runs of full-scale positive and negative samples and a single impulse.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLICE = 2'd1,
        ST_EMIT  = 2'd2
    } dafir_state_e;

endpackage

// File: rtl/dafir_lut.sv
// Partial-sum table for one tap group: entry a holds the sum of the
// coefficients whose address bit is set in a.
module dafir_lut #(
    parameter int unsigned CW   = 12,
    parameter int unsigned PART = 4,
    parameter int unsigned LW   = 15,
    parameter logic [PART*CW-1:0] PCOEF = '0
) (
    input  logic [PART-1:0]        addr,
    output logic signed [LW-1:0]   value
);
    localparam int unsigned DEPTH = 1 << PART;

    function automatic logic signed [LW-1:0] entry(input int unsigned a);
        logic signed [LW-1:0] s;
        s = '0;
        for (int t = 0; t < int'(PART); t++) begin
            if (a[t]) begin
                s = s + LW'($signed(PCOEF[t*CW +: CW]));
            end
        end
        return s;
    endfunction

    logic signed [LW-1:0] rom [DEPTH];

    for (genvar a = 0; a < int'(DEPTH); a++) begin : g_ent
        assign rom[a] = entry(a);
    end

    assign value = rom[addr];

endmodule

// File: rtl/dafir_plane.sv
// One bit plane: gathers bit bidx of every tap, looks up each group and
// adds the group partial sums.
module dafir_plane #(
    parameter int unsigned DATA_W = 12,
    parameter int unsigned NTAPS  = 8,
    parameter int unsigned PART   = 4,
    parameter int unsigned CW     = 12,
    parameter int unsigned LW     = 15,
    parameter int unsigned ACC_W  = 27,
    parameter int unsigned IW     = 4,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic [NTAPS*DATA_W-1:0]  taps,
    input  logic [IW-1:0]            bidx,
    output logic signed [ACC_W-1:0]  psum
);
    localparam int unsigned NPART = NTAPS / PART;

    logic signed [LW-1:0] grp_val [NPART];

    for (genvar p = 0; p < int'(NPART); p++) begin : g_grp
        logic [PART-1:0] addr;
        always_comb begin
            for (int t = 0; t < int'(PART); t++) begin
                addr[t] = taps[(p*PART + t)*DATA_W + int'(bidx)];
            end
        end
        dafir_lut #(
            .CW   (CW),
            .PART (PART),
            .LW   (LW),
            .PCOEF(COEFS[p*PART*CW +: PART*CW])
        ) u_lut (
            .addr (addr),
            .value(grp_val[p])
        );
    end

    always_comb begin
        psum = '0;
        for (int p = 0; p < int'(NPART); p++) begin
            psum = psum + ACC_W'(grp_val[p]);
        end
    end

endmodule

// File: rtl/dafir_fir.sv
module dafir_fir
    import dafir_pkg::*;
#(
    parameter int unsigned DATA_W     = 12,
    parameter int unsigned CW         = 12,
    parameter int unsigned NTAPS      = 8,
    parameter int unsigned PART       = 4,
    parameter int unsigned RADIX_BITS = 2,
    parameter logic [NTAPS*CW-1:0] COEFS = {
        12'sd33, -12'sd90, 12'sd700, -12'sd2048,
        12'sd2047, 12'sd1023, -12'sd300, 12'sd150},
    localparam int unsigned OUT_W = CW + DATA_W + $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_en,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [OUT_W-1:0]  out_data
);
    localparam int unsigned NSLICE = DATA_W / RADIX_BITS;
    localparam int unsigned LW     = CW + $clog2(PART) + 1;
    localparam int unsigned IW     = $clog2(DATA_W);
    localparam int unsigned SCW    = $clog2(NSLICE + 1);
    localparam int unsigned LINE_W = NTAPS * DATA_W;

    if ((NTAPS % PART) != 0) begin : g_bad_part
        $error("NTAPS must be a multiple of PART");
    end
    if ((DATA_W % RADIX_BITS) != 0) begin : g_bad_radix
        $error("DATA_W must be a multiple of RADIX_BITS");
    end

    dafir_state_e               state_q, state_d;
    logic [LINE_W-1:0]          taps_q;
    logic [SCW-1:0]             slice_q;
    logic signed [OUT_W-1:0]    acc_q;
    logic signed [OUT_W-1:0]    slice_sum;
    logic signed [OUT_W-1:0]    plane_sum [RADIX_BITS];
    logic                       accept;

    assign accept = in_en && (state_q == ST_IDLE || state_q == ST_EMIT);

    // One plane (table set) per bit handled in a clock.
    for (genvar j = 0; j < int'(RADIX_BITS); j++) begin : g_plane
        logic [IW-1:0] bidx;
        always_comb begin
            bidx = IW'(int'(DATA_W) - int'(RADIX_BITS) * (int'(slice_q) + 1) + j);
        end
        dafir_plane #(
            .DATA_W(DATA_W),
            .NTAPS (NTAPS),
            .PART  (PART),
            .CW    (CW),
            .LW    (LW),
            .ACC_W (OUT_W),
            .IW    (IW),
            .COEFS (COEFS)
        ) u_plane (
            .taps(taps_q),
            .bidx(bidx),
            .psum(plane_sum[j])
        );
    end

    // Weight planes inside the slice; the sign bit plane is subtracted.
    always_comb begin
        slice_sum = '0;
        for (int j = 0; j < int'(RADIX_BITS); j++) begin
            if (slice_q == '0 && j == int'(RADIX_BITS) - 1) begin
                slice_sum = slice_sum - (plane_sum[j] <<< j);
            end else begin
                slice_sum = slice_sum + (plane_sum[j] <<< j);
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_en) state_d = ST_SLICE;
            ST_SLICE: if (slice_q == SCW'(NSLICE - 1)) state_d = ST_EMIT;
            ST_EMIT:  state_d = in_en ? ST_SLICE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Delay line, slice counter and MSB-first shift accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taps_q  <= '0;
            slice_q <= '0;
            acc_q   <= '0;
        end else if (accept) begin
            taps_q  <= {taps_q[LINE_W-DATA_W-1:0], in_data};
            slice_q <= '0;
            acc_q   <= '0;
        end else if (state_q == ST_SLICE) begin
            acc_q   <= (acc_q <<< RADIX_BITS) + slice_sum;
            slice_q <= slice_q + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= (state_q == ST_EMIT);
            if (state_q == ST_EMIT) begin
                out_data <= acc_q;
            end
        end
    end

    // Assertions
    p_valid_after_emit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(state_q) == ST_EMIT));

    p_slice_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLICE) |-> (slice_q < SCW'(NSLICE)));

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLICE && in_en) |=> $stable(taps_q));

    p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_data) |-> out_valid);

endmodule

// File: tb/dafir_fir_test.sv
module dafir_fir_test;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 12;
    localparam int CW     = 12;
    localparam int NTAPS  = 8;
    localparam int RB     = 2;
    localparam int NSLICE = DATA_W / RB;
    localparam int OUT_W  = CW + DATA_W + $clog2(NTAPS);
    localparam logic [NTAPS*CW-1:0] COEFS = {
        12'sd33, -12'sd90, 12'sd700, -12'sd2048,
        12'sd2047, 12'sd1023, -12'sd300, 12'sd150};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_en = 1'b0;
    logic signed [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic signed [OUT_W-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dafir_fir #(.DATA_W(DATA_W), .CW(CW), .NTAPS(NTAPS), .PART(4),
                .RADIX_BITS(RB), .COEFS(COEFS)) uut (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data));

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    bit mon_on = 0;
    longint hist [NTAPS];
    longint expq [0:4095];
    int wr = 0;
    int rd = 0;
    bit prev_valid = 0;
    logic signed [OUT_W-1:0] prev_data = '0;

    function automatic longint coef(int i);
        return longint'($signed(COEFS[i*CW +: CW]));
    endfunction

    function automatic longint model_out();
        longint s = 0;
        for (int i = 0; i < NTAPS; i++) s += coef(i) * hist[i];
        return s;
    endfunction

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Offer one sample at a negedge that the design will accept; returns one negedge later.
    task automatic issue(logic signed [DATA_W-1:0] x);
        @(negedge clk);
        in_en = 1'b1;
        in_data = x;
        for (int i = NTAPS-1; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'(x);
        expq[wr] = model_out();
        wr++;
        @(negedge clk);
        in_en = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4*NSLICE && rd != wr; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(rd == wr, "R2 result count", rd, wr);
    endtask

    // Output monitor: R2/R3 values, R5 pulse width, R8 hold
    always @(negedge clk) begin
        if (mon_on) begin
            if (prev_valid) chk(!out_valid, "R5 pulse width", out_valid, 0);
            if (out_valid) begin
                if (rd == wr) begin
                    chk(1'b0, "R6 unexpected result", longint'(out_data), 0);
                end else begin
                    chk(longint'(out_data) == expq[rd], "R2/R3 filter value",
                        longint'(out_data), expq[rd]);
                    rd++;
                end
            end else if (prev_valid || (rd > 0 && wr > rd)) begin
                chk(out_data == prev_data, "R8 hold", longint'(out_data),
                    longint'(prev_data));
            end
            prev_valid = out_valid;
            prev_data = out_data;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int cnt;
        void'($urandom(32'h5EED_0D1A));
        for (int i = 0; i < NTAPS; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        chk(out_data == '0, "R1 data in reset", longint'(out_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
        chk(out_data == '0, "R1 data after reset", longint'(out_data), 0);
        mon_on = 1'b1;

        // R4: latency of a single sample; also R1 (zero history) and tap order via impulse
        issue(12'sd1);
        cnt = 1;
        while (!out_valid && cnt < 50) begin @(negedge clk); cnt++; end
        chk(cnt == NSLICE + 2, "R4 latency", cnt, NSLICE + 2);
        for (int k = 0; k < NTAPS; k++) begin
            issue(12'sd0);
            repeat (NSLICE) @(negedge clk);
        end
        drain();

        // R3: most negative and most positive full-scale runs
        for (int k = 0; k < NTAPS + 2; k++) begin
            issue(-12'sd2048);
            repeat (NSLICE - 1) @(negedge clk);
        end
        for (int k = 0; k < NTAPS + 2; k++) begin
            issue(12'sd2047);
            repeat (NSLICE - 1) @(negedge clk);
        end
        for (int k = 0; k < NTAPS; k++) begin
            issue((k % 2) ? 12'sd2047 : -12'sd2048);
            repeat (NSLICE - 1) @(negedge clk);
        end
        drain();

        // R6: strobes while busy carry bogus values and must be ignored
        for (int k = 0; k < 6; k++) begin
            issue(DATA_W'($urandom));
            @(negedge clk);
            in_en = 1'b1; in_data = 12'sh7FF;
            @(negedge clk);
            in_en = 1'b0;
            @(negedge clk);
            in_en = 1'b1; in_data = -12'sd2048;
            @(negedge clk);
            in_en = 1'b0;
            repeat (NSLICE) @(negedge clk);
        end
        drain();

        // R7 back-to-back and random gaps with random data
        for (int k = 0; k < 300; k++) begin
            issue(DATA_W'($urandom));
            if (k % 3 == 0) repeat (NSLICE - 1) @(negedge clk);
            else repeat (NSLICE - 1 + int'($urandom_range(0, 5))) @(negedge clk);
        end
        drain();
        chk(wr >= 300, "R7 samples issued", wr, 300);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule